// File: doc/BRIEF.md
# Shared Packed-Integer / Floating-Point Register File with Tags

This block is the storage behind two execution units that share one register set. It holds eight 80-bit entries. The floating-point side sees each entry as a full extended-precision value. The packed-integer (SIMD) side sees only the low 64 bits of each entry. The SIMD side addresses entries directly by index. It has two combinational read ports and one write port. Each entry carries a 2-bit occupancy tag. The whole set of tags is presented as a 16-bit word, which lets context-switch logic skip saving an empty file.

A SIMD write stores its 64-bit payload in the low half of the target entry and forces the top 16 bits to ones. Every SIMD access, read or write, marks all eight tags valid at once. A separate clear command marks all tags empty without touching any data. A small floating-point push/pop port writes full entries and flips single tags, so that the tag transitions of the stack side can be driven.

Top module: `sfr_shared_regs`

## Requirements
- R1: After reset every tag is empty (tag word 16'hFFFF) and every entry reads as zero on all read ports.
- R2: A SIMD write with index i stores its 64-bit data in bits 63:0 of entry i. From the next cycle, a SIMD read port given index i returns that data.
- R3: A SIMD write sets bits 79:64 of the target entry to all ones. This is visible on the floating-point read port from the next cycle.
- R4: Any cycle with a SIMD read enable or write enable asserted (and no clear) makes the tag word 16'h0000 in the next cycle. Tag code 2'b00 means valid.
- R5: The clear command makes the tag word 16'hFFFF in the next cycle (tag code 2'b11 means empty). All entry contents stay unchanged, so a later SIMD read returns the old data.
- R6: A floating-point push with index i writes all 80 bits of entry i and sets tag i to valid. The other tags are unchanged.
- R7: A floating-point pop with index i sets tag i to empty. The entry's data is unchanged.
- R8: When the clear command and a SIMD write fall in the same cycle, the tags end up all empty and the write still lands.
- R9: A SIMD read of the entry being written in the same cycle returns the old value. There is no write-through path.
- R10: The two SIMD read ports return different entries independently in the same cycle.
- R11: The tag of entry i occupies tag word bits 2i+1:2i (entry 0 in bits 1:0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rda_en | input | 1 | SIMD read port A access strobe (revalidates tags) |
| rda_idx | input | 3 | SIMD read port A entry index |
| rda_data | output | 64 | SIMD read port A data (low 64 bits of entry) |
| rdb_en | input | 1 | SIMD read port B access strobe (revalidates tags) |
| rdb_idx | input | 3 | SIMD read port B entry index |
| rdb_data | output | 64 | SIMD read port B data |
| wr_en | input | 1 | SIMD write enable |
| wr_idx | input | 3 | SIMD write entry index |
| wr_data | input | 64 | SIMD write data |
| clr | input | 1 | Clear SIMD state: all tags empty, data kept |
| fp_push | input | 1 | Floating-point push: write full entry, tag valid |
| fp_push_idx | input | 3 | Push destination entry |
| fp_push_data | input | 80 | Push data |
| fp_pop | input | 1 | Floating-point pop: tag of entry becomes empty |
| fp_pop_idx | input | 3 | Pop entry |
| fp_rd_idx | input | 3 | Floating-point read index |
| fp_rd_data | output | 80 | Full 80-bit entry contents |
| tag_word | output | 16 | All tags, entry i at bits 2i+1:2i |

## Verification
The SIMD write path is tried with several data patterns: alternating bits, all zeros and all ones, each at a different index. These show whether the low half is stored exactly and whether the forced upper ones come from the write itself rather than from the data. Read-only accesses are run separately from writes, which shows whether revalidation is tied to any SIMD access or only to writes. Single push and pop operations make single-tag edits that expose the tag-word bit placement. These are set against the bulk clear and the clear-with-write collision, which show the priority between the tag sources and that the data path is independent of it. A same-index read during a write shows the absence of a bypass.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
   typedef enum logic [1:0] {
      TAG_VALID = 2'b00,
      TAG_EMPTY = 2'b11
   } tag_e;
endpackage

// File: rtl/sfr_store.sv
module sfr_store #(
   parameter int NREG   = 8,
   parameter int LOW_W  = 64,
   parameter int HIGH_W = 16,
   localparam int ROW_W = LOW_W + HIGH_W,
   localparam int IW    = $clog2(NREG)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [IW-1:0]              wr_idx,
   input  logic [LOW_W-1:0]           wr_data,
   input  logic                       push_en,
   input  logic [IW-1:0]              push_idx,
   input  logic [ROW_W-1:0]           push_data,
   input  logic                       clr,
   output logic [NREG-1:0][ROW_W-1:0] mem_o
);
   // SIMD write takes the row when both paths aim at the same entry
   for (genvar g = 0; g < NREG; g++) begin : g_row
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mem_o[g] <= '0;
         end else if (wr_en && wr_idx == IW'(g)) begin
            mem_o[g] <= {{HIGH_W{1'b1}}, wr_data};
         end else if (push_en && push_idx == IW'(g)) begin
            mem_o[g] <= push_data;
         end
      end
   end

   a_r2_low_written: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> mem_o[$past(wr_idx)][LOW_W-1:0] == $past(wr_data));
   a_r3_high_ones: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> mem_o[$past(wr_idx)][ROW_W-1:LOW_W] == {HIGH_W{1'b1}});
   a_r5_clear_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !wr_en && !push_en) |=> $stable(mem_o));
endmodule

// File: rtl/sfr_tags.sv
module sfr_tags
   import sfr_pkg::*;
#(
   parameter int NREG = 8,
   localparam int IW  = $clog2(NREG)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 simd_act,
   input  logic                 push_en,
   input  logic [IW-1:0]        push_idx,
   input  logic                 pop_en,
   input  logic [IW-1:0]        pop_idx,
   output logic [NREG-1:0][1:0] tags_o
);
   logic [NREG-1:0][1:0] nxt;

   // priority: clear, then bulk revalidate, then single-entry edits
   for (genvar g = 0; g < NREG; g++) begin : g_tag
      always_comb begin
         if (clr)                                nxt[g] = TAG_EMPTY;
         else if (simd_act)                      nxt[g] = TAG_VALID;
         else if (push_en && push_idx == IW'(g)) nxt[g] = TAG_VALID;
         else if (pop_en && pop_idx == IW'(g))   nxt[g] = TAG_EMPTY;
         else                                    nxt[g] = tags_o[g];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tags_o[g] <= TAG_EMPTY;
         else        tags_o[g] <= nxt[g];
      end
   end

   a_r5_clear_all_empty: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> tags_o == {NREG{TAG_EMPTY}});
   a_r4_access_all_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (simd_act && !clr) |=> tags_o == '0);
   a_r6_push_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (push_en && !clr && !simd_act) |=> tags_o[$past(push_idx)] == TAG_VALID);
   a_r7_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_en && !push_en && !clr && !simd_act) |=> tags_o[$past(pop_idx)] == TAG_EMPTY);
endmodule

// File: rtl/sfr_rdmux.sv
module sfr_rdmux #(
   parameter int NREG  = 8,
   parameter int ROW_W = 80,
   parameter int OUT_W = 64,
   localparam int IW   = $clog2(NREG)
) (
   input  logic [NREG-1:0][ROW_W-1:0] mem_i,
   input  logic [IW-1:0]              idx,
   output logic [OUT_W-1:0]           data_o
);
   if (OUT_W > ROW_W) begin : g_bad_width
      $error("read width exceeds row width");
   end

   if (OUT_W == ROW_W) begin : g_full
      assign data_o = mem_i[idx];
   end else begin : g_low
      logic [ROW_W-1:0] row;
      assign row    = mem_i[idx];
      assign data_o = row[OUT_W-1:0];
   end
endmodule

// File: rtl/sfr_shared_regs.sv
module sfr_shared_regs #(
   parameter int NREG   = 8,
   parameter int LOW_W  = 64,
   parameter int HIGH_W = 16,
   localparam int ROW_W = LOW_W + HIGH_W,
   localparam int IW    = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rda_en,
   input  logic [IW-1:0]     rda_idx,
   output logic [LOW_W-1:0]  rda_data,
   input  logic              rdb_en,
   input  logic [IW-1:0]     rdb_idx,
   output logic [LOW_W-1:0]  rdb_data,
   input  logic              wr_en,
   input  logic [IW-1:0]     wr_idx,
   input  logic [LOW_W-1:0]  wr_data,
   input  logic              clr,
   input  logic              fp_push,
   input  logic [IW-1:0]     fp_push_idx,
   input  logic [ROW_W-1:0]  fp_push_data,
   input  logic              fp_pop,
   input  logic [IW-1:0]     fp_pop_idx,
   input  logic [IW-1:0]     fp_rd_idx,
   output logic [ROW_W-1:0]  fp_rd_data,
   output logic [2*NREG-1:0] tag_word
);
   if (NREG < 2 || (1 << IW) != NREG) begin : g_bad_depth
      $error("entry count must be a power of two of at least 2");
   end
   if (LOW_W < 1 || HIGH_W < 1) begin : g_bad_split
      $error("both row fields need at least one bit");
   end

   logic [NREG-1:0][ROW_W-1:0] mem;
   logic [NREG-1:0][1:0]       tags;
   logic                       simd_act;

   assign simd_act = rda_en | rdb_en | wr_en;
   assign tag_word = tags;

   sfr_store #(.NREG(NREG), .LOW_W(LOW_W), .HIGH_W(HIGH_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .push_en(fp_push), .push_idx(fp_push_idx), .push_data(fp_push_data),
      .clr(clr), .mem_o(mem)
   );

   sfr_tags #(.NREG(NREG)) u_tags (
      .clk(clk), .rst_n(rst_n), .clr(clr), .simd_act(simd_act),
      .push_en(fp_push), .push_idx(fp_push_idx),
      .pop_en(fp_pop), .pop_idx(fp_pop_idx), .tags_o(tags)
   );

   sfr_rdmux #(.NREG(NREG), .ROW_W(ROW_W), .OUT_W(LOW_W)) u_rda (
      .mem_i(mem), .idx(rda_idx), .data_o(rda_data));
   sfr_rdmux #(.NREG(NREG), .ROW_W(ROW_W), .OUT_W(LOW_W)) u_rdb (
      .mem_i(mem), .idx(rdb_idx), .data_o(rdb_data));
   sfr_rdmux #(.NREG(NREG), .ROW_W(ROW_W), .OUT_W(ROW_W)) u_rdf (
      .mem_i(mem), .idx(fp_rd_idx), .data_o(fp_rd_data));

   a_r8_clear_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && wr_en) |=> (tag_word == '1 && mem[$past(wr_idx)][LOW_W-1:0] == $past(wr_data)));
endmodule

// File: tb/tb_sfr_shared_regs.sv
module tb_sfr_shared_regs;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        rda_en = 0, rdb_en = 0, wr_en = 0, clr = 0, fp_push = 0, fp_pop = 0;
   logic [2:0]  rda_idx = 0, rdb_idx = 0, wr_idx = 0, fp_push_idx = 0, fp_pop_idx = 0, fp_rd_idx = 0;
   logic [63:0] wr_data = 0, rda_data, rdb_data;
   logic [79:0] fp_push_data = 0, fp_rd_data;
   logic [15:0] tag_word;
   int total = 0, bad = 0;
   bit done = 0;

   localparam logic [63:0] PA = 64'hA5A5_5A5A_0F0F_F0F0;
   localparam logic [79:0] PX = 80'h3FFF_8000_0000_0000_0001;

   always #5 clk = ~clk;

   sfr_shared_regs dut (.*);

   task automatic chk(string req, logic [79:0] act, logic [79:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic idle();
      rda_en = 0; rdb_en = 0; wr_en = 0; clr = 0; fp_push = 0; fp_pop = 0;
   endtask

   task automatic simd_write(logic [2:0] i, logic [63:0] d);
      wr_en = 1; wr_idx = i; wr_data = d; tick(); idle();
   endtask

   task automatic t_reset();
      chk("R1 tags", 80'(tag_word), 80'hFFFF);
      rda_idx = 2; rdb_idx = 6; fp_rd_idx = 4; #1;
      chk("R1 rda", 80'(rda_data), 0);
      chk("R1 rdb", 80'(rdb_data), 0);
      chk("R1 fp", fp_rd_data, 0);
   endtask

   task automatic t_write();
      simd_write(3, PA);
      rda_idx = 3; fp_rd_idx = 3; #1;
      chk("R2 data", 80'(rda_data), 80'(PA));
      chk("R3 upper", fp_rd_data, {16'hFFFF, PA});
      chk("R4 after write", 80'(tag_word), 0);
      simd_write(6, 64'h0);
      fp_rd_idx = 6; #1;
      chk("R3 zero data", fp_rd_data, {16'hFFFF, 64'h0});
      simd_write(2, '1);
      rdb_idx = 2; #1;
      chk("R2 ones", 80'(rdb_data), 80'({64{1'b1}}));
   endtask

   task automatic t_clear();
      clr = 1; tick(); idle();
      rda_idx = 3; #1;
      chk("R5 tags", 80'(tag_word), 80'hFFFF);
      chk("R5 data kept", 80'(rda_data), 80'(PA));
      rdb_en = 1; rdb_idx = 6; tick(); idle();
      chk("R4 read only", 80'(tag_word), 0);
      clr = 1; tick(); idle();
   endtask

   task automatic t_push_pop();
      fp_push = 1; fp_push_idx = 5; fp_push_data = PX; tick(); idle();
      fp_rd_idx = 5; #1;
      chk("R6 data", fp_rd_data, PX);
      chk("R6 R11 tags", 80'(tag_word), 80'hF3FF);
      fp_push = 1; fp_push_idx = 0; fp_push_data = 80'h1; tick(); idle();
      chk("R11 entry0", 80'(tag_word), 80'hF3FC);
      fp_pop = 1; fp_pop_idx = 5; tick(); idle();
      chk("R7 tags", 80'(tag_word), 80'hFFFC);
      chk("R7 data", fp_rd_data, PX);
   endtask

   task automatic t_clr_write();
      clr = 1; wr_en = 1; wr_idx = 1; wr_data = 64'h1234_5678_9ABC_DEF0; tick(); idle();
      rda_idx = 1; #1;
      chk("R8 tags", 80'(tag_word), 80'hFFFF);
      chk("R8 data", 80'(rda_data), 80'h1234_5678_9ABC_DEF0);
   endtask

   task automatic t_no_bypass();
      wr_en = 1; wr_idx = 3; wr_data = 64'hC0DE; rda_en = 1; rda_idx = 3; #1;
      chk("R9 old value", 80'(rda_data), 80'(PA));
      tick(); idle(); #1;
      chk("R9 new value", 80'(rda_data), 80'hC0DE);
   endtask

   task automatic t_two_ports();
      simd_write(0, 64'h1111_2222_3333_4444);
      simd_write(7, 64'h8888_9999_AAAA_BBBB);
      rda_en = 1; rdb_en = 1; rda_idx = 0; rdb_idx = 7; #1;
      chk("R10 port a", 80'(rda_data), 80'h1111_2222_3333_4444);
      chk("R10 port b", 80'(rdb_data), 80'h8888_9999_AAAA_BBBB);
      tick(); idle();
   endtask

   initial begin
      #200000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      tick();
      t_reset();
      t_write();
      t_clear();
      t_push_pop();
      t_clr_write();
      t_no_bypass();
      t_two_ports();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule